// File: doc/BRIEF.md
# Software Write-Protect Command Detector

This block sits beside the page-write controller of a byte-wide nonvolatile memory and examines every byte the host loads into a page. It looks for two fixed command sequences of address and data pairs at the start of a load. The three-byte unlock sequence either turns protection on or lets one protected load through. The six-byte clear sequence turns protection off. The protect state is kept in a register that an ordinary reset leaves alone, standing in for nonvolatile storage. Only the separate power-on initialisation input clears it.

The page-write controller uses three outputs. `cmd_suppress` marks, in the same cycle, each byte that the detector takes as a command byte, so that the byte is never stored. `commit_en` tells the controller whether the current load may be stored once its programming period runs. `protect_on` is the persistent state itself. A load without the prefix while protected still goes through the write timer, but `commit_en` stays low and nothing is stored.

The host byte stream (`wr_valid`, `wr_addr`, `wr_data`) has no back-pressure. Every byte with `wr_valid` high is accepted in that cycle. Bytes offered while a programming period is running are dropped by this block. The load-window expiry (`load_timeout`) and end-of-programming (`prog_done`) inputs are single-cycle pulses from the page-write controller.

Top module: `wp_seq_detect`

## Requirements
- R1: While `por_n` is low at a clock edge, `protect_on` is cleared to 0 and the detector returns to its start. A low `rst_n` resets the detector but leaves `protect_on` unchanged.
- R2: A load that begins with data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555 (address bits 14:0) arms protection. `protect_on` becomes 1 in the cycle after the next `prog_done` pulse and not earlier, even if no data byte follows the three command bytes.
- R3: A load that begins with 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 arms clearing. `protect_on` becomes 0 in the cycle after the next `prog_done` pulse.
- R4: `cmd_suppress` is high in the same cycle as an accepted byte exactly when that byte equals the next expected command byte of a sequence. It is never high without `wr_valid`.
- R5: A byte that differs in address or data from the expected command byte is not suppressed. For the rest of that load no byte is taken as a command byte, even one that looks like the first byte of a sequence.
- R6: `commit_en` is 1 whenever `protect_on` is 0. While protected, `commit_en` is 1 from the cycle after the unlock prefix (or the full clear sequence) completes until the cycle after `prog_done`, and 0 otherwise.
- R7: Bytes offered from the `load_timeout` pulse up to and including the `prog_done` pulse are ignored. They are never suppressed and they do not advance a sequence.
- R8: A `load_timeout` abandons a partial sequence without arming anything. The next load is matched from its first byte again.
- R9: A protected load without the prefix leaves `commit_en` at 0 through its programming period and leaves `protect_on` at 1 after `prog_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, spares the protect state |
| por_n | input | 1 | Synchronous active-low power-on initialisation, clears protect state |
| wr_valid | input | 1 | Host byte write strobe, always accepted |
| wr_addr | input | 15 | Low address bits of the byte |
| wr_data | input | 8 | Data byte |
| load_timeout | input | 1 | Pulse: byte-load window expired, programming starts |
| prog_done | input | 1 | Pulse: programming period finished |
| protect_on | output | 1 | Persistent software write-protect state |
| commit_en | output | 1 | Current load may be stored |
| cmd_suppress | output | 1 | Current byte is a command byte and is not stored |

## Verification
The hardest situations to reach are the mid-sequence mismatches. The clear sequence only diverges from the unlock sequence at its third byte, so both a corrupt fourth-to-sixth byte and an 0x80 path abandoned by a timeout need several exact bytes in a row. Random stimulus would almost never produce them. The bench therefore builds each random load from a chosen template: an unlock prefix, a clear sequence, a truncated prefix, or a prefix with one corrupted byte at a random step. It also mixes in writes during the programming window and occasional detector resets.

// File: rtl/wp_pkg.sv
package wp_pkg;

  localparam int AW    = 15;
  localparam int DW    = 8;
  localparam int NSTEP = 6;
  localparam int SW    = 3;

  localparam logic [AW-1:0] ADR_HI = 15'h5555;
  localparam logic [AW-1:0] ADR_LO = 15'h2AAA;

  localparam logic [DW-1:0] K_LEAD  = 8'hAA;
  localparam logic [DW-1:0] K_NEXT  = 8'h55;
  localparam logic [DW-1:0] K_ARM   = 8'hA0;
  localparam logic [DW-1:0] K_EXT   = 8'h80;
  localparam logic [DW-1:0] K_CLEAR = 8'h20;

  typedef enum logic [SW-1:0] {
    ST_C0, ST_C1, ST_C2, ST_C3, ST_C4, ST_C5, ST_PASS
  } step_e;

  function automatic logic [AW-1:0] slot_addr(input int idx);
    case (idx)
      1, 4:    return ADR_LO;
      default: return ADR_HI;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_data(input int idx);
    case (idx)
      0, 3:    return K_LEAD;
      1, 4:    return K_NEXT;
      2:       return K_EXT;
      default: return K_CLEAR;
    endcase
  endfunction

endpackage

// File: rtl/wp_cmd_matcher.sv
module wp_cmd_matcher
  import wp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          take,
  input  logic          restart,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          hit,
  output logic          arm_seen,
  output logic          clr_seen
);

  step_e              step_q, step_d;
  logic [NSTEP-1:0]   slot_hit;
  logic               arm_hit;

  for (genvar gi = 0; gi < NSTEP; gi++) begin : g_slot
    assign slot_hit[gi] = (step_q == step_e'(SW'(gi))) &&
                          (addr == slot_addr(gi)) &&
                          (data == slot_data(gi));
  end

  assign arm_hit  = (step_q == ST_C2) && (addr == ADR_HI) && (data == K_ARM);
  assign hit      = take && ((|slot_hit) || arm_hit);
  assign arm_seen = take && arm_hit;
  assign clr_seen = take && slot_hit[NSTEP-1];

  always_comb begin
    step_d = step_q;
    if (restart) begin
      step_d = ST_C0;
    end else if (take) begin
      if (arm_hit || slot_hit[NSTEP-1]) begin
        step_d = ST_PASS;
      end else if (|slot_hit) begin
        step_d = step_e'(step_q + SW'(1));
      end else begin
        step_d = ST_PASS;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      step_q <= ST_C0;
    end else begin
      step_q <= step_d;
    end
  end

endmodule

// File: rtl/wp_protect_state.sv
module wp_protect_state (
  input  logic clk,
  input  logic rst_n,
  input  logic por_n,
  input  logic arm_seen,
  input  logic clr_seen,
  input  logic load_end,
  input  logic prog_done,
  output logic protect_q,
  output logic unlocked_q,
  output logic busy_q
);

  logic pend_arm_q;
  logic pend_clr_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      protect_q  <= 1'b0;
      unlocked_q <= 1'b0;
      busy_q     <= 1'b0;
      pend_arm_q <= 1'b0;
      pend_clr_q <= 1'b0;
    end else if (!rst_n) begin
      unlocked_q <= 1'b0;
      busy_q     <= 1'b0;
      pend_arm_q <= 1'b0;
      pend_clr_q <= 1'b0;
    end else if (prog_done) begin
      if (pend_arm_q) begin
        protect_q <= 1'b1;
      end else if (pend_clr_q) begin
        protect_q <= 1'b0;
      end
      unlocked_q <= 1'b0;
      busy_q     <= 1'b0;
      pend_arm_q <= 1'b0;
      pend_clr_q <= 1'b0;
    end else begin
      if (load_end) begin
        busy_q <= 1'b1;
      end
      if (arm_seen) begin
        pend_arm_q <= 1'b1;
        pend_clr_q <= 1'b0;
        unlocked_q <= 1'b1;
      end
      if (clr_seen) begin
        pend_clr_q <= 1'b1;
        pend_arm_q <= 1'b0;
        unlocked_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wp_seq_detect.sv
module wp_seq_detect
  import wp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          load_timeout,
  input  logic          prog_done,
  output logic          protect_on,
  output logic          commit_en,
  output logic          cmd_suppress
);

  logic take;
  logic restart;
  logic arm_seen;
  logic clr_seen;
  logic protect_q;
  logic unlocked_q;
  logic busy_q;

  assign take    = wr_valid && !busy_q && !load_timeout && !prog_done;
  assign restart = load_timeout || prog_done;

  wp_cmd_matcher u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_n    (por_n),
    .take     (take),
    .restart  (restart),
    .addr     (wr_addr),
    .data     (wr_data),
    .hit      (cmd_suppress),
    .arm_seen (arm_seen),
    .clr_seen (clr_seen)
  );

  wp_protect_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_n      (por_n),
    .arm_seen   (arm_seen),
    .clr_seen   (clr_seen),
    .load_end   (load_timeout),
    .prog_done  (prog_done),
    .protect_q  (protect_q),
    .unlocked_q (unlocked_q),
    .busy_q     (busy_q)
  );

  assign protect_on = protect_q;
  assign commit_en  = !protect_q || unlocked_q;

endmodule

// File: rtl/wp_seq_detect_chk.sv
module wp_seq_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic por_n,
  input logic wr_valid,
  input logic load_timeout,
  input logic prog_done,
  input logic protect_on,
  input logic commit_en,
  input logic cmd_suppress
);

  logic primed;
  logic win_busy;

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      primed   <= 1'b0;
      win_busy <= 1'b0;
    end else begin
      primed <= 1'b1;
      if (prog_done) begin
        win_busy <= 1'b0;
      end else if (load_timeout) begin
        win_busy <= 1'b1;
      end
    end
  end

  // R4
  suppress_needs_write_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    cmd_suppress |-> wr_valid);

  // R7
  no_cmd_in_prog_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (win_busy || load_timeout || prog_done) |-> !cmd_suppress);

  // R2
  protect_rise_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (primed && $rose(protect_on)) |-> $past(prog_done));

  // R3
  protect_fall_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (primed && $fell(protect_on)) |-> $past(prog_done));

  // R6
  commit_after_prog_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (primed && $past(prog_done)) |-> (commit_en == !protect_on));

endmodule

bind wp_seq_detect wp_seq_detect_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .por_n        (por_n),
  .wr_valid     (wr_valid),
  .load_timeout (load_timeout),
  .prog_done    (prog_done),
  .protect_on   (protect_on),
  .commit_en    (commit_en),
  .cmd_suppress (cmd_suppress)
);

// File: tb/wp_seq_detect_tb.sv
module wp_seq_detect_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        load_timeout = 1'b0;
  logic        prog_done = 1'b0;
  logic        protect_on;
  logic        commit_en;
  logic        cmd_suppress;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int m_step = 0;
  bit m_unl = 0, m_busy = 0, m_pa = 0, m_pc = 0, m_prot = 0;

  always #10 clk = ~clk;

  wp_seq_detect u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_timeout(load_timeout), .prog_done(prog_done),
    .protect_on(protect_on), .commit_en(commit_en), .cmd_suppress(cmd_suppress)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // 0 none, 1 advance, 2 unlock done, 3 clear done
  function automatic int m_kind(input int st, input logic [14:0] a, input logic [7:0] d);
    case (st)
      0: return (a == 15'h5555 && d == 8'hAA) ? 1 : 0;
      1: return (a == 15'h2AAA && d == 8'h55) ? 1 : 0;
      2: begin
        if (a == 15'h5555 && d == 8'hA0) return 2;
        return (a == 15'h5555 && d == 8'h80) ? 1 : 0;
      end
      3: return (a == 15'h5555 && d == 8'hAA) ? 1 : 0;
      4: return (a == 15'h2AAA && d == 8'h55) ? 1 : 0;
      5: return (a == 15'h5555 && d == 8'h20) ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic cyc(input bit wr, input logic [14:0] a, input logic [7:0] d,
                     input bit tmo, input bit dn);
    int kind;
    bit take;
    @(negedge clk);
    chk(protect_on, m_prot, "R1/R2/R3/R9 protect_on");
    chk(commit_en, !m_prot || m_unl, "R6 commit_en");
    wr_valid = wr; wr_addr = a; wr_data = d; load_timeout = tmo; prog_done = dn;
    #2;
    take = wr && !m_busy && !tmo && !dn;
    kind = take ? m_kind(m_step, a, d) : 0;
    chk(cmd_suppress, kind != 0, "R4/R5/R7/R8 cmd_suppress");
    if (dn) begin
      if (m_pa) m_prot = 1; else if (m_pc) m_prot = 0;
      m_pa = 0; m_pc = 0; m_unl = 0; m_busy = 0; m_step = 0;
    end else if (tmo) begin
      m_busy = 1; m_step = 0;
    end else if (take) begin
      if (kind == 2) begin m_pa = 1; m_pc = 0; m_unl = 1; m_step = 6; end
      else if (kind == 3) begin m_pc = 1; m_pa = 0; m_unl = 1; m_step = 6; end
      else if (kind == 1) m_step = m_step + 1;
      else m_step = 6;
    end
    @(posedge clk);
  endtask

  task automatic idle(); cyc(0, '0, '0, 0, 0); endtask
  task automatic wb(input logic [14:0] a, input logic [7:0] d); cyc(1, a, d, 0, 0); endtask
  task automatic finish_load(); cyc(0, '0, '0, 1, 0); idle(); cyc(0, '0, '0, 0, 1); endtask
  task automatic unlock3(); wb(15'h5555, 8'hAA); wb(15'h2AAA, 8'h55); wb(15'h5555, 8'hA0); endtask
  task automatic clear6();
    wb(15'h5555, 8'hAA); wb(15'h2AAA, 8'h55); wb(15'h5555, 8'h80);
    wb(15'h5555, 8'hAA); wb(15'h2AAA, 8'h55); wb(15'h5555, 8'h20);
  endtask

  task automatic power_on();
    @(negedge clk); por_n = 0; rst_n = 0; wr_valid = 0; load_timeout = 0; prog_done = 0;
    repeat (3) @(posedge clk);
    m_step = 0; m_unl = 0; m_busy = 0; m_pa = 0; m_pc = 0; m_prot = 0;
    @(negedge clk); por_n = 1; rst_n = 1;
  endtask

  task automatic det_reset();
    @(negedge clk); rst_n = 0; wr_valid = 0; load_timeout = 0; prog_done = 0;
    @(posedge clk);
    m_step = 0; m_unl = 0; m_busy = 0; m_pa = 0; m_pc = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1 reset state after power-on
    power_on();
    idle();
    // unprotected plain write stores, no suppress (R6)
    wb(15'h0123, 8'h5A); finish_load();
    // R2 protection arms, takes effect only after prog_done
    unlock3(); cyc(0, '0, '0, 1, 0); idle(); idle();
    cyc(0, '0, '0, 0, 1); idle();
    // R9 protected write without prefix
    wb(15'h0040, 8'h11); wb(15'h0041, 8'h22); finish_load(); idle();
    // R1 detector reset leaves protection
    det_reset(); idle();
    // R6 + R7 unlock with data, busy-window command bytes ignored
    unlock3(); wb(15'h0100, 8'h33);
    cyc(0, '0, '0, 1, 0); wb(15'h5555, 8'hAA); wb(15'h2AAA, 8'h55);
    cyc(0, '0, '0, 0, 1); idle();
    // R5 mismatch on address, later lead byte is data
    wb(15'h5555, 8'hAA); wb(15'h2AAB, 8'h55); wb(15'h5555, 8'hAA); finish_load();
    // R8 timeout abandons partial sequence
    wb(15'h5555, 8'hAA); wb(15'h2AAA, 8'h55); finish_load();
    wb(15'h5555, 8'hA0); finish_load();
    // R3 clear sequence
    clear6(); finish_load(); idle();
    // R1 power-on clears protection
    unlock3(); finish_load(); idle();
    power_on(); idle();

    // constrained random loads
    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 5);
      int nb = $urandom_range(0, 4);
      if ($urandom_range(0, 30) == 0) det_reset();
      case (kind)
        0: unlock3();
        1: clear6();
        2: begin
          int cut = $urandom_range(1, 5);
          if (cut >= 1) wb(15'h5555, 8'hAA);
          if (cut >= 2) wb(15'h2AAA, 8'h55);
          if (cut >= 3) wb(15'h5555, 8'h80);
          if (cut >= 4) wb(15'h5555, 8'hAA);
          if (cut >= 5) wb(15'h2AAA, 8'h55);
          wb(($urandom_range(0, 1) != 0) ? 15'h5555 : 15'h2AAA, 8'($urandom_range(0, 255)));
        end
        3: begin
          wb(15'h5555, 8'hAA);
          wb(15'h2AAA, ($urandom_range(0, 1) != 0) ? 8'h55 : 8'h54);
          wb(15'h5555, ($urandom_range(0, 1) != 0) ? 8'hA0 : 8'h80);
        end
        default: ;
      endcase
      for (int b = 0; b < nb; b++) wb(15'($urandom_range(0, 32767)), 8'($urandom_range(0, 255)));
      cyc(0, '0, '0, 1, 0);
      for (int b = 0; b < int'($urandom_range(0, 2)); b++) wb(15'h5555, 8'hAA);
      cyc(0, '0, '0, 0, 1);
    end
    idle();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule